// File: doc/BRIEF.md
# Resumable Iterative Divider

This block divides a dividend by a 16-bit divisor and produces one quotient bit per accepted step. It does not count its own cycles. A repeat mechanism outside the block issues step commands through a per-cycle step enable. A start pulse latches the operands and the mode. After that, exactly 19 accepted steps finish the operation:

- one setup step that captures the signs and loads the magnitudes;
- sixteen shift-and-subtract iterations, one quotient bit each;
- one step that fixes the sign of the quotient;
- one step that fixes the sign of the remainder.

The step enable may drop between any two steps, for example while an interrupt is serviced. All partial state is held while it is low, so the operation resumes where it stopped. Four modes are available: signed 16/16 integer, signed 32/16 integer, signed fractional, and unsigned 32/16 integer. A zero divisor is flagged as soon as the operands are latched.

Top module: `iter_divider`

## Requirements
- R1: `mode` selects the operation. 2'b00 is signed 16/16 integer, 2'b01 is signed 32/16 integer, 2'b10 is signed fractional and 2'b11 is unsigned 32/16 integer. In 16/16 and fractional modes only `dividend[15:0]` is used, and the upper 16 bits have no effect.
- R2: After synchronous reset, `done`, `div_zero`, `quotient` and `remainder` are all 0. A step enable given before any start has no effect.
- R3: A start pulse latches the operands and the mode, and clears `done` on the following edge. When start and step enable are high in the same cycle, start wins and that step is not counted.
- R4: `done` rises on the clock edge that accepts the 19th step after a start, and not earlier.
- R5: While step enable is low, `quotient`, `remainder` and `done` hold their values. Pauses of any length at any point leave the final result unchanged.
- R6: In the signed integer modes, the quotient truncates toward zero and the remainder takes the sign of the dividend. Results are valid when the true quotient fits in 16 signed bits.
- R7: In 16/16 mode the dividend is `dividend[15:0]` taken as a signed value.
- R8: In fractional mode the quotient is (N·2^15)/D, truncated toward zero, where N is `dividend[15:0]`. The remainder takes the sign of N. Results are valid for |N| < |D|.
- R9: In unsigned mode both operands are unsigned. Results are valid when the quotient is below 2^16.
- R10: `div_zero` is updated on the edge after each start. It is 1 exactly when the divisor latched by that start is zero. The operation still completes in 19 steps, and its outputs hold once `done` is set.
- R11: Once `done` is set, further step enables are ignored and all outputs stay stable until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch operands and mode, and begin a new operation |
| step_en | input | 1 | Perform one step in this cycle |
| dividend | input | 32 | Dividend (only the low half is used in 16-bit and fractional modes) |
| divisor | input | 16 | Divisor |
| mode | input | 2 | Operation select (see R1) |
| quotient | output | 16 | Quotient, valid while done is high |
| remainder | output | 16 | Remainder, valid while done is high |
| done | output | 1 | Operation complete |
| div_zero | output | 1 | Latched divisor was zero |

## Verification
A new start and an outstanding step can arrive in the same cycle, as happens when a fresh divide is issued while a previous one is half finished. The bench provokes this by asserting start together with step enable after a few steps of an earlier operation. It then counts the steps still needed: `done` must stay low after 18 more steps and rise on the 19th, and the result must belong to the second operand set. A second overlap is also checked: step enables arriving after completion must leave every output frozen.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    MD_S16  = 2'b00,
    MD_S32  = 2'b01,
    MD_FRAC = 2'b10,
    MD_U32  = 2'b11
  } div_mode_t;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_ITER  = 2'd1,
    PH_FIXQ  = 2'd2,
    PH_FIXR  = 2'd3
  } div_phase_t;
endpackage

// File: rtl/div_step_seq.sv
module div_step_seq
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       step_en,
  output logic       adv,
  output div_phase_t phase,
  output logic       done
);
  localparam int NSTEPS = W + 3;
  localparam int CW = $clog2(NSTEPS);
  localparam logic [CW-1:0] LAST = CW'(NSTEPS - 1);
  localparam logic [CW-1:0] FIXQ_AT = CW'(W + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  // a start in the same cycle suppresses the step
  assign adv = busy & step_en & ~start;

  always_comb begin
    if (cnt == '0)            phase = PH_SETUP;
    else if (cnt < FIXQ_AT)   phase = PH_ITER;
    else if (cnt == FIXQ_AT)  phase = PH_FIXQ;
    else                      phase = PH_FIXR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      done <= 1'b0;
    end else if (adv) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2*W-1:0] num,
  input  logic [W-1:0]   den,
  input  div_mode_t      mode,
  output logic [2*W-1:0] num_mag,
  output logic [W-1:0]   den_mag,
  output logic           neg_quo,
  output logic           neg_rem
);
  localparam int NW = 2 * W;

  logic [NW-1:0] num_ext;
  logic          is_signed;
  logic          num_neg;
  logic          den_neg;

  always_comb begin
    case (mode)
      MD_S16:  num_ext = {{W{num[W-1]}}, num[W-1:0]};
      MD_FRAC: num_ext = {{W{num[W-1]}}, num[W-1:0]} << (W - 1);
      default: num_ext = num;
    endcase
    is_signed = (mode != MD_U32);
    num_neg   = is_signed & num_ext[NW-1];
    den_neg   = is_signed & den[W-1];
    num_mag   = num_neg ? (~num_ext + 1'b1) : num_ext;
    den_mag   = den_neg ? (~den + 1'b1) : den;
    neg_quo   = num_neg ^ den_neg;
    neg_rem   = num_neg;
  end
endmodule

// File: rtl/div_iter_stage.sv
module div_iter_stage #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] quo_in,
  input  logic [W-1:0] den_mag,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] quo_out
);
  logic [W:0] part;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    part    = {rem_in, quo_in[W-1]};
    diff    = part - {1'b0, den_mag};
    fits    = (part >= {1'b0, den_mag});
    rem_out = fits ? diff[W-1:0] : part[W-1:0];
    quo_out = {quo_in[W-2:0], fits};
  end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           step_en,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic [1:0]     mode,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           done,
  output logic           div_zero
);
  localparam int NW = 2 * W;

  logic [NW-1:0] num_q;
  logic [W-1:0]  den_q;
  div_mode_t     mode_q;
  logic [W-1:0]  rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dmag_q;
  logic          negq_q;
  logic          negr_q;
  logic          dz_q;

  logic          adv;
  div_phase_t    phase;
  logic [NW-1:0] num_mag;
  logic [W-1:0]  den_mag;
  logic          neg_quo;
  logic          neg_rem;
  logic [W-1:0]  rem_nxt;
  logic [W-1:0]  quo_nxt;

  div_step_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .step_en(step_en),
    .adv(adv), .phase(phase), .done(done)
  );

  div_operand_prep #(.W(W)) u_prep (
    .num(num_q), .den(den_q), .mode(mode_q),
    .num_mag(num_mag), .den_mag(den_mag),
    .neg_quo(neg_quo), .neg_rem(neg_rem)
  );

  div_iter_stage #(.W(W)) u_iter (
    .rem_in(rem_q), .quo_in(quo_q), .den_mag(dmag_q),
    .rem_out(rem_nxt), .quo_out(quo_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q  <= '0;
      den_q  <= '0;
      mode_q <= MD_S16;
      rem_q  <= '0;
      quo_q  <= '0;
      dmag_q <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      dz_q   <= 1'b0;
    end else if (start) begin
      num_q  <= dividend;
      den_q  <= divisor;
      mode_q <= div_mode_t'(mode);
      dz_q   <= (divisor == '0);
      rem_q  <= '0;
      quo_q  <= '0;
    end else if (adv) begin
      case (phase)
        PH_SETUP: begin
          rem_q  <= num_mag[NW-1:W];
          quo_q  <= num_mag[W-1:0];
          dmag_q <= den_mag;
          negq_q <= neg_quo;
          negr_q <= neg_rem;
        end
        PH_ITER: begin
          rem_q <= rem_nxt;
          quo_q <= quo_nxt;
        end
        PH_FIXQ: if (negq_q) quo_q <= ~quo_q + 1'b1;
        default: if (negr_q) rem_q <= ~rem_q + 1'b1;
      endcase
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign div_zero  = dz_q;
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         step_en,
  input logic [W-1:0] divisor,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         done,
  input logic         div_zero
);
  // R3
  start_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);

  // R5
  pause_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !step_en) |=> ($stable(quotient) && $stable(remainder) && $stable(done)));

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(quotient) && $stable(remainder)));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (div_zero == ($past(divisor) == '0)));

  // R4
  done_needs_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(step_en) && !$past(start)));
endmodule

bind iter_divider div_checker #(.W(W)) u_div_checker (
  .clk(clk), .rst(rst), .start(start), .step_en(step_en),
  .divisor(divisor), .quotient(quotient), .remainder(remainder),
  .done(done), .div_zero(div_zero)
);

// File: tb/tb_iter_divider.sv
module tb_iter_divider;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEPS = 19;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic        step_en;
  logic [31:0] dividend;
  logic [15:0] divisor;
  logic [1:0]  mode;
  logic [15:0] quotient;
  logic [15:0] remainder;
  logic        done;
  logic        div_zero;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  iter_divider dut (
    .clk(clk), .rst(rst), .start(start), .step_en(step_en),
    .dividend(dividend), .divisor(divisor), .mode(mode),
    .quotient(quotient), .remainder(remainder),
    .done(done), .div_zero(div_zero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ref_div(input logic [31:0] n, input logic [15:0] d, input logic [1:0] m,
                         output logic [15:0] q, output logic [15:0] r);
    longint ns, ds, qq, rr;
    case (m)
      2'b00: begin ns = longint'($signed(n[15:0])); ds = longint'($signed(d)); end
      2'b01: begin ns = longint'($signed(n)); ds = longint'($signed(d)); end
      2'b10: begin ns = longint'($signed(n[15:0])) * 32768; ds = longint'($signed(d)); end
      default: begin ns = longint'({32'b0, n}); ds = longint'({48'b0, d}); end
    endcase
    qq = ns / ds;
    rr = ns % ds;
    q = qq[15:0];
    r = rr[15:0];
  endtask

  task automatic do_start(input logic [31:0] n, input logic [15:0] d, input logic [1:0] m,
                          input logic with_step);
    dividend = n; divisor = d; mode = m; start = 1'b1; step_en = with_step;
    @(negedge clk);
    start = 1'b0; step_en = 1'b0;
  endtask

  task automatic do_steps(input int count, input int pause_pct);
    int k = 0;
    while (k < count) begin
      if (pause_pct > 0 && $urandom_range(99) < pause_pct) step_en = 1'b0;
      else begin step_en = 1'b1; k++; end
      @(negedge clk);
    end
    step_en = 1'b0;
  endtask

  task automatic run_check(input string req, input logic [31:0] n, input logic [15:0] d,
                           input logic [1:0] m, input int pause_pct);
    logic [15:0] eq, er;
    ref_div(n, d, m, eq, er);
    do_start(n, d, m, 1'b0);
    do_steps(NSTEPS, pause_pct);
    chk({req, " done"}, {31'b0, done}, 32'd1);
    chk({req, " quotient"}, {16'b0, quotient}, {16'b0, eq});
    chk({req, " remainder"}, {16'b0, remainder}, {16'b0, er});
  endtask

  task automatic t_reset;
    rst = 1'b1; start = 1'b0; step_en = 1'b0;
    dividend = '0; divisor = '0; mode = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 done", {31'b0, done}, 32'd0);
    chk("R2 div_zero", {31'b0, div_zero}, 32'd0);
    chk("R2 quotient", {16'b0, quotient}, 32'd0);
    chk("R2 remainder", {16'b0, remainder}, 32'd0);
    do_steps(25, 0);
    chk("R2 step before start", {31'b0, done}, 32'd0);
    chk("R2 outputs after stray steps", {quotient, remainder}, 32'd0);
  endtask

  task automatic t_signed16;
    run_check("R7 R6 R1 s16 -7/2", 32'hDEAD_FFF9, 16'd2, 2'b00, 0);
    run_check("R7 R6 s16 100/-7", 32'h1234_0064, 16'hFFF9, 2'b00, 30);
    run_check("R7 R6 s16 -32768/3", 32'h0000_8000, 16'd3, 2'b00, 0);
  endtask

  task automatic t_signed32;
    run_check("R6 R1 s32 1000000/-300", 32'd1000000, 16'hFED4, 2'b01, 0);
    run_check("R6 s32 -1000000/301", -32'sd1000000, 16'd301, 2'b01, 40);
    run_check("R6 s32 -65535/-2", -32'sd65535, 16'hFFFE, 2'b01, 0);
  endtask

  task automatic t_frac;
    run_check("R8 R1 frac 0.25/0.5", 32'hFFFF_2000, 16'h4000, 2'b10, 0);
    run_check("R8 frac -0.3/0.7", {16'h0, 16'hD99A}, 16'h599A, 2'b10, 25);
    run_check("R8 frac 0.1/-0.9", {16'h0, 16'h0CCD}, 16'h8CCD, 2'b10, 0);
  endtask

  task automatic t_unsigned;
    run_check("R9 R1 u32 big", 32'hFFF0_1234, 16'hFFFF, 2'b11, 0);
    run_check("R9 u32 small", 32'd123456, 16'd7, 2'b11, 50);
  endtask

  task automatic t_count;
    logic [15:0] eq, er;
    ref_div(32'd5000, 16'd7, 2'b01, eq, er);
    do_start(32'd5000, 16'd7, 2'b01, 1'b0);
    chk("R3 done cleared by start", {31'b0, done}, 32'd0);
    do_steps(NSTEPS - 1, 20);
    chk("R4 done low after 18 steps", {31'b0, done}, 32'd0);
    do_steps(1, 0);
    chk("R4 done after 19th step", {31'b0, done}, 32'd1);
    chk("R4 quotient", {16'b0, quotient}, {16'b0, eq});
  endtask

  task automatic t_pause;
    logic [15:0] eq, er, hq, hr;
    ref_div(-32'sd77777, 16'd313, 2'b01, eq, er);
    do_start(-32'sd77777, 16'd313, 2'b01, 1'b0);
    do_steps(9, 0);
    hq = quotient; hr = remainder;
    repeat (6) @(negedge clk);
    chk("R5 pause holds quotient", {16'b0, quotient}, {16'b0, hq});
    chk("R5 pause holds remainder", {16'b0, remainder}, {16'b0, hr});
    chk("R5 pause holds done", {31'b0, done}, 32'd0);
    do_steps(NSTEPS - 9, 60);
    chk("R5 resumed quotient", {16'b0, quotient}, {16'b0, eq});
    chk("R5 resumed remainder", {16'b0, remainder}, {16'b0, er});
  endtask

  task automatic t_collide;
    logic [15:0] eq, er;
    ref_div(32'd999, 16'hFFF6, 2'b01, eq, er);
    do_start(32'd40000, 16'd9, 2'b11, 1'b0);
    do_steps(7, 0);
    do_start(32'd999, 16'hFFF6, 2'b01, 1'b1);
    do_steps(NSTEPS - 1, 0);
    chk("R3 colliding step not counted", {31'b0, done}, 32'd0);
    do_steps(1, 0);
    chk("R3 done after restart", {31'b0, done}, 32'd1);
    chk("R3 restart quotient", {16'b0, quotient}, {16'b0, eq});
    chk("R3 restart remainder", {16'b0, remainder}, {16'b0, er});
  endtask

  task automatic t_after_done;
    logic [15:0] hq, hr;
    run_check("R11 base", 32'd4321, 16'd10, 2'b00, 0);
    hq = quotient; hr = remainder;
    do_steps(8, 0);
    chk("R11 done stays", {31'b0, done}, 32'd1);
    chk("R11 quotient frozen", {16'b0, quotient}, {16'b0, hq});
    chk("R11 remainder frozen", {16'b0, remainder}, {16'b0, hr});
  endtask

  task automatic t_zero;
    logic [15:0] hq;
    do_start(32'd1234, 16'd0, 2'b01, 1'b0);
    chk("R10 div_zero set", {31'b0, div_zero}, 32'd1);
    do_steps(NSTEPS, 30);
    chk("R10 completes on zero divisor", {31'b0, done}, 32'd1);
    hq = quotient;
    do_steps(3, 0);
    chk("R10 zero result stable", {16'b0, quotient}, {16'b0, hq});
    do_start(32'd1234, 16'd5, 2'b01, 1'b0);
    chk("R10 div_zero cleared", {31'b0, div_zero}, 32'd0);
  endtask

  initial begin
    void'($urandom(7));
    t_reset();
    t_signed16();
    t_signed32();
    t_frac();
    t_unsigned();
    t_count();
    t_pause();
    t_collide();
    t_after_done();
    t_zero();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule